// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is a boundary-scan data register for a set of bidirectional general-purpose pins. Each pin has three scan cells: one watches the pad input, one holds a value for the pad output, and one holds an active-low drive enable. The cells of all pins form one serial chain. A test access port controller outside the block operates the chain. It does so through a select line, capture, shift and update strobes, and a mode bit that picks external test.

While the chain is not in external test, the pads carry the core's output value and output enable. A capture loads a snapshot of the pins into the chain. An update stores the shifted data in the update latches without touching the pads, which lets a pattern be preloaded. In external test, the pads are driven from those latches.

A scan that stops before an update leaves the pad drive as it was. A chain can therefore be read back without driving the pattern that was shifted in to replace it.

Top module: `bscan_pin_chain`

## Requirements
- R1: The chain holds 3×NPINS cells. For pin p, cell 3p is the input cell, cell 3p+1 is the output cell and cell 3p+2 is the control cell.
- R2: Each clock with `sel` and `shift` high and `capture` low moves the chain one cell toward index 0. `scan_in` enters cell 3×NPINS−1 and `scan_out` always shows cell 0, so cell 0 is read first.
- R3: A clock with `sel` and `capture` high loads each input cell with `pad_in[p]`, each output cell with `pad_out[p]` and each control cell with the inverse of `pad_oe[p]`.
- R4: The update latches load the whole chain on a clock with `sel` and `update` high. They change on no other clock.
- R5: With `mode_extest` high, `pad_out[p]` equals output latch 3p+1. `pad_oe[p]` is high exactly when control latch 3p+2 is 0, so a loaded 1 tristates the pad.
- R6: With `mode_extest` low, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`, whatever the latches hold. This includes directly after a preload.
- R7: While `rst_n` is low, every control latch holds 1 and every output latch holds 0, so in external test no pad is driven.
- R8: In external test, a scan that ends without an update leaves `pad_out` and `pad_oe` unchanged.
- R9: The chain holds its contents on any clock without `sel`, or without both a capture and a shift strobe.
- R10: `core_in` always equals `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low TAP reset |
| sel | input | 1 | This register is the selected data register |
| capture | input | 1 | Controller is in Capture-DR |
| shift | input | 1 | Controller is in Shift-DR |
| update | input | 1 | Controller is in Update-DR |
| mode_extest | input | 1 | Decoded external-test instruction |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out, cell 0 |
| core_out | input | NPINS | Functional output values |
| core_oe | input | NPINS | Functional output enables, high drives |
| core_in | output | NPINS | Pad input values returned to the core |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad drive enables, high drives |
| pad_in | input | NPINS | Pad input values |

## Verification
All 256 combinations of core value and enable are applied with the functional path active. This shows that the pads and `core_in` follow the core whatever the latches hold.

Sixteen pad-input patterns are captured and read back against varied core drive. This tells the placement of input, output and control bits apart and confirms the order in which they leave the chain.

Eight preload patterns are first checked in sample mode and then in external test, which separates latching from driving. A scan that ends without an update, an update and a shift with select low, and a strobe burst with select low show that only a selected update changes the pins.

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             mode_extest,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] core_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  input  logic [NPINS-1:0] pad_in
);
  localparam int LEN = 3 * NPINS;

  function automatic logic [LEN-1:0] ctl_mask();
    logic [LEN-1:0] m = '0;
    for (int p = 0; p < NPINS; p++) m[3*p+2] = 1'b1;
    return m;
  endfunction
  localparam logic [LEN-1:0] UPD_RST = ctl_mask();

  logic [LEN-1:0] sh, upd, snap;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign snap[3*p]   = pad_in[p];
    assign snap[3*p+1] = pad_out[p];
    assign snap[3*p+2] = ~pad_oe[p];
    assign pad_out[p]  = mode_extest ? upd[3*p+1] : core_out[p];
    assign pad_oe[p]   = mode_extest ? ~upd[3*p+2] : core_oe[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sh <= '0;
    else if (sel && capture)   sh <= snap;
    else if (sel && shift)     sh <= {scan_in, sh[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              upd <= UPD_RST;
    else if (sel && update)  upd <= sh;
  end

  assign scan_out = sh[0];
  assign core_in  = pad_in;
endmodule

module bscan_pin_chain_chk #(
  parameter int NPINS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel,
  input logic                 capture,
  input logic                 shift,
  input logic                 update,
  input logic                 mode_extest,
  input logic                 scan_in,
  input logic                 scan_out,
  input logic [NPINS-1:0]     pad_out,
  input logic [NPINS-1:0]     pad_oe,
  input logic [3*NPINS-1:0]   sh,
  input logic [3*NPINS-1:0]   upd
);
  localparam int LEN = 3 * NPINS;
  logic armed = 1'b0;

  always_ff @(posedge clk) armed <= 1'b1;

  a_r9_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && (capture || shift)) |=> $stable(sh));

  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && shift && !capture) |=>
      (sh[LEN-1] == $past(scan_in)) && (sh[LEN-2:0] == $past(sh[LEN-1:1])) && (scan_out == sh[0]));

  a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && update) |=> $stable(upd));

  a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && update) |=> upd == $past(sh));

  a_r8_pause_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_extest && !(sel && update)) ##1 mode_extest |-> $stable(pad_out) && $stable(pad_oe));

  always @(negedge clk) begin
    if (armed && !rst_n) begin
      for (int p = 0; p < NPINS; p++) begin
        a_r7_reset_latch: assert (upd[3*p+2] == 1'b1 && upd[3*p+1] == 1'b0);
      end
    end
  end
endmodule

bind bscan_pin_chain bscan_pin_chain_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .capture(capture), .shift(shift),
  .update(update), .mode_extest(mode_extest), .scan_in(scan_in),
  .scan_out(scan_out), .pad_out(pad_out), .pad_oe(pad_oe), .sh(sh), .upd(upd)
);

// File: tb/sim_bscan_pin_chain.sv
module sim_bscan_pin_chain;
  localparam int PERIOD = 10;
  localparam int N = 4;
  localparam int L = 3 * N;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, capture = 0, shift = 0, update = 0, mode_extest = 0, scan_in = 0;
  logic scan_out;
  logic [N-1:0] core_out = '0, core_oe = '0, core_in, pad_out, pad_oe, pad_in = '0;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  bscan_pin_chain #(.NPINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .capture(capture), .shift(shift),
    .update(update), .mode_extest(mode_extest), .scan_in(scan_in),
    .scan_out(scan_out), .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic scan(input logic [L-1:0] din, input bit cap, input bit upd,
                      output logic [L-1:0] dout);
    if (cap) begin capture = 1; tick(); capture = 0; end
    shift = 1;
    for (int i = 0; i < L; i++) begin
      dout[i] = scan_out;
      scan_in = din[i];
      tick();
    end
    shift = 0;
    if (upd) begin update = 1; tick(); update = 0; end
  endtask

  function automatic logic [L-1:0] exp_snap(logic [N-1:0] pi, logic [N-1:0] po, logic [N-1:0] poe);
    logic [L-1:0] r;
    for (int p = 0; p < N; p++) begin
      r[3*p] = pi[p]; r[3*p+1] = po[p]; r[3*p+2] = ~poe[p];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_out(logic [L-1:0] pat);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = pat[3*p+1];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_oe(logic [L-1:0] pat);
    logic [N-1:0] r;
    for (int p = 0; p < N; p++) r[p] = ~pat[3*p+2];
    return r;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [L-1:0] dout, p_last, q, r;
    tick(); tick();
    mode_extest = 1; #1;
    check("R7 reset pad_oe", pad_oe, '0);
    check("R7 reset pad_out", pad_out, '0);
    mode_extest = 0;
    rst_n = 1;
    tick();

    for (int v = 0; v < 256; v++) begin
      core_out = v[3:0]; core_oe = v[7:4]; pad_in = ~v[3:0]; #1;
      check("R6 sample pad_out", pad_out, core_out);
      check("R6 sample pad_oe", pad_oe, core_oe);
      check("R10 core_in", core_in, pad_in);
      tick();
    end

    sel = 1;
    for (int k = 0; k < 16; k++) begin
      logic [N-1:0] co, ce;
      co = N'(k * 5); ce = N'(k ^ 9);
      pad_in = N'(k); core_out = co; core_oe = ce;
      scan('0, 1, 0, dout);
      check("R3 R1 R2 capture readback", dout, exp_snap(N'(k), co, ce));
    end

    core_out = 4'b0110; core_oe = 4'b1010;
    p_last = '0;
    for (int k = 0; k < 8; k++) begin
      logic [L-1:0] pat;
      pat = L'(k * 12'h2B5) ^ 12'h9C3;
      scan(pat, 0, 1, dout);
      #1;
      check("R6 preload pad_out", pad_out, core_out);
      check("R6 preload pad_oe", pad_oe, core_oe);
      mode_extest = 1; #1;
      check("R5 R4 extest pad_out", pad_out, exp_out(pat));
      check("R5 R4 extest pad_oe", pad_oe, exp_oe(pat));
      mode_extest = 0;
      p_last = pat;
      tick();
    end

    mode_extest = 1; pad_in = 4'b1001;
    q = 12'h5A6;
    scan(q, 1, 0, dout);
    #1;
    check("R8 pause pad_out", pad_out, exp_out(p_last));
    check("R8 pause pad_oe", pad_oe, exp_oe(p_last));
    check("R3 extest capture", dout, exp_snap(4'b1001, exp_out(p_last), exp_oe(p_last)));
    update = 1; tick(); update = 0; #1;
    check("R4 update pad_out", pad_out, exp_out(q));
    check("R4 update pad_oe", pad_oe, exp_oe(q));

    r = 12'h3C9;
    scan(r, 0, 0, dout);
    sel = 0; shift = 1; capture = 1; scan_in = 1;
    tick(); tick(); tick();
    shift = 0; capture = 0; update = 1;
    tick(); update = 0; #1;
    check("R4 unselected update pad_out", pad_out, exp_out(q));
    check("R4 unselected update pad_oe", pad_oe, exp_oe(q));
    sel = 1; update = 1; tick(); update = 0; #1;
    check("R9 chain held pad_out", pad_out, exp_out(r));
    check("R9 chain held pad_oe", pad_oe, exp_oe(r));

    finished = 1;
    summary();
  end
endmodule